// File: doc/BRIEF.md
# Multi-Lane Serial Byte Shifter

This block is the bit-level engine of a serial flash master. It moves exactly one byte per request across a serial bus in mode 0 (clock idles low, data sampled on the rising edge), using one, two or four data lanes. Each byte goes in one direction only. A write byte drives the lanes and ignores the input. A read byte samples the input lanes and either releases the bus (dual and quad) or holds the single output line low (single). An outer sequencer frames commands around it, owns chip select and adds any dummy clocks. That sequencer issues one start pulse per byte and waits for the done pulse.

The serial clock rate is set by a half-period count in system clocks. The count is taken at the moment a byte is accepted, so changing it mid-byte has no effect. Data always travels most significant first. In dual mode the upper bit pair goes first, and in quad mode the upper nibble goes first.

Top module: `spi_multilane_shifter`

## Requirements
- R1: Out of reset and between bytes, `sck` is 0, `busy` and `done` are 0, `io_out` is 4'b0000 and `io_oe` is 4'b0001.
- R2: A `start` pulse while idle is accepted when `lane_sel` is 0 (single), 1 (dual) or 2 (quad). The code 3 is rejected, and then `busy` stays 0 and no `done` follows.
- R3: Every low and every high phase of `sck` lasts h system clocks. h is the value of `half_div` sampled at acceptance, with 0 treated as 1. Later changes to `half_div` do not affect the byte in flight.
- R4: A byte takes 8 (single), 4 (dual) or 2 (quad) `sck` clocks. `busy` stays high for exactly 2*clocks*h cycles. `done` is a one-cycle pulse in the first cycle after `busy` falls.
- R5: Write data leaves most significant first. Single mode uses `io_out[0]`, one bit per clock. Dual mode uses `io_out[1:0]`, with bits [7:6] first. Quad mode uses `io_out[3:0]`, with bits [7:4] first.
- R6: `io_out` changes only while `sck` is low, and it is stable for the whole high phase.
- R7: Read data is captured at each rising `sck` edge and shifted in most significant first. Single mode samples `io_in[1]`, dual mode samples `io_in[1:0]` and quad mode samples `io_in[3:0]`. The assembled byte appears on `rx_byte` when `done` pulses.
- R8: While busy, `io_oe` is 4'b0001 in single mode (either direction), 4'b0011 for dual writes, 4'b1111 for quad writes and 4'b0000 for dual or quad reads.
- R9: During a single-lane read, `io_out[0]` is held at 0 for the whole byte.
- R10: A `start` pulse while `busy` is ignored. The byte in flight finishes unchanged and no extra `done` is produced.
- R11: A write byte leaves `rx_byte` unchanged. `rx_byte` holds the last read byte until the next read completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_div | input | DIV_W | Half-period of `sck` in system clocks (0 acts as 1) |
| start | input | 1 | Request to move one byte |
| lane_sel | input | 2 | 0 single, 1 dual, 2 quad, 3 rejected |
| dir_rd | input | 1 | 1 read byte, 0 write byte |
| tx_byte | input | 8 | Byte to send on a write |
| busy | output | 1 | A byte is in flight |
| done | output | 1 | One-cycle completion pulse |
| rx_byte | output | 8 | Last byte read |
| sck | output | 1 | Serial clock, idles low |
| io_out | output | 4 | Lane output data |
| io_oe | output | 4 | Per-lane output enable |
| io_in | input | 4 | Lane input data |

## Verification
A wrong phase or clock-count state shows up within the affected byte. It appears as a wrong number of `sck` rising edges, a high phase of the wrong length, or a `busy` window of the wrong length at the next `done`. A wrong shift register or lane select shows up as a corrupted byte. The bench reassembles the byte from `io_out` at each rising edge, or reads `rx_byte` at `done`, so the error is flagged at the end of the same byte. Wrong enable decoding is flagged at the first rising edge of the byte. A start accepted while busy, or a rejected lane code, produces a `done` the scoreboard does not expect.

// File: rtl/spi_lane_pkg.sv
package spi_lane_pkg;

  typedef enum logic [1:0] {
    LANE_X1 = 2'd0,
    LANE_X2 = 2'd1,
    LANE_X4 = 2'd2
  } lane_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  localparam int BYTE_W = 8;
  localparam int CLK_W  = 4;

  // sck clocks needed for one byte in each lane mode
  function automatic logic [CLK_W-1:0] lane_clocks(input lane_e m);
    case (m)
      LANE_X2: lane_clocks = CLK_W'(4);
      LANE_X4: lane_clocks = CLK_W'(2);
      default: lane_clocks = CLK_W'(8);
    endcase
  endfunction

endpackage

// File: rtl/half_period_timer.sv
module half_period_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [DIV_W-1:0] div_in,
  input  logic             run,
  output logic             expire
);

  logic [DIV_W-1:0] reload_q, reload_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] arm_val;

  // a zero divider behaves as one system clock per half period
  assign arm_val = (div_in == '0) ? '0 : div_in - DIV_W'(1);
  assign expire  = run && (cnt_q == '0);

  always_comb begin
    reload_d = reload_q;
    cnt_d    = cnt_q;
    if (arm) begin
      reload_d = arm_val;
      cnt_d    = arm_val;
    end else if (run) begin
      cnt_d = (cnt_q == '0) ? reload_q : cnt_q - DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      cnt_q    <= '0;
    end else if (arm || run) begin
      reload_q <= reload_d;
      cnt_q    <= cnt_d;
    end
  end

  AST_COUNT_WITHIN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= reload_q)); // R3

endmodule

// File: rtl/shift_sequencer.sv
module shift_sequencer
  import spi_lane_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] lane_sel,
  input  logic       expire,
  output logic       accept,
  output logic       busy,
  output logic       sck,
  output logic       done,
  output logic       shift_en,
  output logic       sample_en,
  output logic       finish
);

  phase_e           state_q, state_d;
  logic [CLK_W-1:0] left_q, left_d;
  logic             done_q;
  logic             mode_ok;

  assign mode_ok = (lane_sel != 2'd3);
  assign accept  = (state_q == PH_IDLE) && start && mode_ok;
  assign busy    = (state_q != PH_IDLE);
  assign sck     = (state_q == PH_HIGH);
  assign done    = done_q;

  always_comb begin
    state_d   = state_q;
    left_d    = left_q;
    shift_en  = 1'b0;
    sample_en = 1'b0;
    finish    = 1'b0;
    case (state_q)
      PH_IDLE: begin
        if (accept) begin
          state_d = PH_LOW;
          left_d  = lane_clocks(lane_e'(lane_sel)) - CLK_W'(1);
        end
      end
      PH_LOW: begin
        if (expire) begin
          state_d   = PH_HIGH;
          sample_en = 1'b1;
        end
      end
      PH_HIGH: begin
        if (expire) begin
          if (left_q == '0) begin
            state_d = PH_IDLE;
            finish  = 1'b1;
          end else begin
            state_d  = PH_LOW;
            left_d   = left_q - CLK_W'(1);
            shift_en = 1'b1;
          end
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      left_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      done_q  <= finish;
    end
  end

  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_CLOCK_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (left_q <= CLK_W'(7))); // R4
  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !expire) |=> ($stable(left_q) && busy)); // R10

endmodule

// File: rtl/lane_shift_path.sv
module lane_shift_path
  import spi_lane_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [1:0]       lane_sel,
  input  logic             dir_rd,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic             busy,
  input  logic             shift_en,
  input  logic             sample_en,
  input  logic             finish,
  input  logic [3:0]       io_in,
  output logic [3:0]       io_out,
  output logic [3:0]       io_oe,
  output logic [BYTE_W-1:0] rx_byte
);

  lane_e             mode_q, mode_d;
  logic              rd_q, rd_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic [BYTE_W-1:0] acc_q, acc_d;
  logic [BYTE_W-1:0] rx_q, rx_d;
  logic              load_en;

  assign load_en = accept || shift_en || sample_en || finish;

  always_comb begin
    mode_d = mode_q;
    rd_d   = rd_q;
    tx_d   = tx_q;
    acc_d  = acc_q;
    rx_d   = rx_q;
    if (accept) begin
      mode_d = lane_e'(lane_sel);
      rd_d   = dir_rd;
      tx_d   = tx_byte;
      acc_d  = '0;
    end
    if (shift_en) begin
      case (mode_q)
        LANE_X2: tx_d = {tx_q[BYTE_W-3:0], 2'b00};
        LANE_X4: tx_d = {tx_q[BYTE_W-5:0], 4'b0000};
        default: tx_d = {tx_q[BYTE_W-2:0], 1'b0};
      endcase
    end
    if (sample_en) begin
      case (mode_q)
        LANE_X2: acc_d = {acc_q[BYTE_W-3:0], io_in[1:0]};
        LANE_X4: acc_d = {acc_q[BYTE_W-5:0], io_in};
        default: acc_d = {acc_q[BYTE_W-2:0], io_in[1]};
      endcase
    end
    if (finish && rd_q) begin
      rx_d = acc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= LANE_X1;
      rd_q   <= 1'b0;
      tx_q   <= '0;
      acc_q  <= '0;
      rx_q   <= '0;
    end else if (load_en) begin
      mode_q <= mode_d;
      rd_q   <= rd_d;
      tx_q   <= tx_d;
      acc_q  <= acc_d;
      rx_q   <= rx_d;
    end
  end

  assign rx_byte = rx_q;

  // pin drive: idle keeps the single output line low and enabled
  always_comb begin
    io_out = 4'b0000;
    io_oe  = 4'b0001;
    if (busy) begin
      case (mode_q)
        LANE_X2: begin
          io_oe  = rd_q ? 4'b0000 : 4'b0011;
          io_out = rd_q ? 4'b0000 : {2'b00, tx_q[BYTE_W-1 -: 2]};
        end
        LANE_X4: begin
          io_oe  = rd_q ? 4'b0000 : 4'b1111;
          io_out = rd_q ? 4'b0000 : tx_q[BYTE_W-1 -: 4];
        end
        default: begin
          io_oe  = 4'b0001;
          io_out = {3'b000, (rd_q ? 1'b0 : tx_q[BYTE_W-1])};
        end
      endcase
    end
  end

  AST_READ_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_q && mode_q == LANE_X1) |-> (io_out == 4'b0000)); // R9
  AST_RX_HELD_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !rd_q) |=> $stable(rx_q)); // R11

endmodule

// File: rtl/spi_multilane_shifter.sv
module spi_multilane_shifter
  import spi_lane_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_div,
  input  logic             start,
  input  logic [1:0]       lane_sel,
  input  logic             dir_rd,
  input  logic [7:0]       tx_byte,
  output logic             busy,
  output logic             done,
  output logic [7:0]       rx_byte,
  output logic             sck,
  output logic [3:0]       io_out,
  output logic [3:0]       io_oe,
  input  logic [3:0]       io_in
);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       accept, expire, shift_en, sample_en, finish;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  half_period_timer #(.DIV_W(DIV_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .arm    (accept),
    .div_in (half_div),
    .run    (busy),
    .expire (expire)
  );

  shift_sequencer u_seq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .start     (start),
    .lane_sel  (lane_sel),
    .expire    (expire),
    .accept    (accept),
    .busy      (busy),
    .sck       (sck),
    .done      (done),
    .shift_en  (shift_en),
    .sample_en (sample_en),
    .finish    (finish)
  );

  lane_shift_path u_path (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .accept    (accept),
    .lane_sel  (lane_sel),
    .dir_rd    (dir_rd),
    .tx_byte   (tx_byte),
    .busy      (busy),
    .shift_en  (shift_en),
    .sample_en (sample_en),
    .finish    (finish),
    .io_in     (io_in),
    .io_out    (io_out),
    .io_oe     (io_oe),
    .rx_byte   (rx_byte)
  );

  AST_IDLE_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_core_n)
    !busy |-> !sck); // R1
  AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_core_n)
    (sck && $past(sck)) |-> $stable(io_out)); // R6
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_core_n)
    done |-> ($past(busy) && !busy)); // R4

endmodule

// File: tb/spi_multilane_shifter_bench.sv
module spi_multilane_shifter_bench;

  typedef struct {
    int         mode;
    bit         rd;
    logic [7:0] tx;
    logic [7:0] rx_exp;
    int         h;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] half_div;
  logic       start;
  logic [1:0] lane_sel;
  logic       dir_rd;
  logic [7:0] tx_byte;
  logic       busy, done, sck;
  logic [7:0] rx_byte;
  logic [3:0] io_out, io_oe, io_in;

  item_t      sb[$];
  int         vectors = 0;
  int         errors  = 0;
  int         rises = 0, busy_cyc = 0, hi_run = 0;
  int         cur_mode = 0, cur_h = 1;
  bit         cur_rd = 1'b0;
  bit         mon_on = 1'b0;
  logic [7:0] pat = 8'h00;
  logic [7:0] pat_sh;
  logic [7:0] txcap = 8'h00;
  logic [7:0] rx_model = 8'h00;
  logic [3:0] io_at_rise = 4'h0;
  logic       sck_d = 1'b0, done_d = 1'b0;

  always #2 clk = ~clk;

  spi_multilane_shifter u_spi_multilane_shifter (
    .clk(clk), .rst_n(rst_n), .half_div(half_div), .start(start),
    .lane_sel(lane_sel), .dir_rd(dir_rd), .tx_byte(tx_byte),
    .busy(busy), .done(done), .rx_byte(rx_byte), .sck(sck),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // slave model: presents the next chunk of pat, decoy data on unused lanes
  always_comb begin
    pat_sh = pat << (rises * (1 << cur_mode));
    io_in  = 4'b0000;
    case (cur_mode)
      1:       io_in = {2'b11, pat_sh[7:6]};
      2:       io_in = pat_sh[7:4];
      default: io_in = {2'b10, pat_sh[7], ~pat_sh[7]};
    endcase
  end

  function automatic logic [3:0] exp_oe(input int m, input bit rd);
    if (m == 0) return 4'b0001;
    if (rd)     return 4'b0000;
    return (m == 1) ? 4'b0011 : 4'b1111;
  endfunction

  // monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (sck && !sck_d) begin
        rises++;
        io_at_rise = io_out;
        case (cur_mode)
          1:       txcap = {txcap[5:0], io_out[1:0]};
          2:       txcap = {txcap[3:0], io_out};
          default: txcap = {txcap[6:0], io_out[0]};
        endcase
        check(io_oe == exp_oe(cur_mode, cur_rd), "R8", "io_oe at rise",
              io_oe, exp_oe(cur_mode, cur_rd));
      end
      if (sck && sck_d && io_out != io_at_rise)
        check(1'b0, "R6", "io_out moved while sck high", io_out, io_at_rise);
      if (sck) hi_run++;
      else if (sck_d) begin
        check(hi_run == cur_h, "R3", "sck high length", hi_run, cur_h);
        hi_run = 0;
      end
      if (busy) busy_cyc++;
      if (done) begin
        if (done_d) check(1'b0, "R4", "done longer than one cycle", 1, 0);
        if (sb.size() == 0) begin
          check(1'b0, "R10", "unexpected done", 1, 0);
        end else begin
          item_t it;
          int    nclk;
          it   = sb.pop_front();
          nclk = 8 >> it.mode;
          check(rises == nclk, "R4", "sck clocks per byte", rises, nclk);
          check(busy_cyc == 2 * nclk * it.h, "R4", "busy cycles", busy_cyc,
                2 * nclk * it.h);
          check(!busy, "R4", "busy low with done", busy, 0);
          check(rx_byte == it.rx_exp, it.rd ? "R7" : "R11", "rx_byte",
                rx_byte, it.rx_exp);
          if (!it.rd)
            check(txcap == it.tx, "R5", "serialised byte", txcap, it.tx);
          else if (it.mode == 0)
            check(txcap == 8'h00, "R9", "MOSI during read", txcap, 0);
        end
        rises = 0; busy_cyc = 0; txcap = 8'h00;
      end
      sck_d  = sck;
      done_d = done;
    end
  end

  task automatic run_byte(input int mode, input bit rd, input logic [7:0] tx,
                          input logic [7:0] p, input int div, input bit poke);
    item_t it;
    @(negedge clk);
    cur_mode = mode; cur_rd = rd; pat = p; cur_h = (div == 0) ? 1 : div;
    half_div = 8'(div); lane_sel = 2'(mode); dir_rd = rd; tx_byte = tx;
    start = 1'b1;
    it.mode = mode; it.rd = rd; it.tx = tx; it.h = cur_h;
    it.rx_exp = rd ? p : rx_model;
    if (rd) rx_model = p;
    sb.push_back(it);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R10 / R3: a second request and a new divider mid-byte change nothing
      repeat (3) @(negedge clk);
      start = 1'b1; tx_byte = ~tx; lane_sel = 2'((mode + 1) % 3);
      dir_rd = ~rd; half_div = 8'(div + 3);
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    check(!sck && !busy, "R1", "idle after byte", {sck, busy}, 0);
    check(io_oe == 4'b0001 && io_out == 4'b0000, "R1", "idle pins",
          {io_oe, io_out}, 8'h10);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; half_div = 8'd1; lane_sel = 2'd0;
    dir_rd = 1'b0; tx_byte = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!sck && !busy && !done, "R1", "reset outputs", {sck, busy, done}, 0);
    check(io_oe == 4'b0001 && io_out == 4'b0000 && rx_byte == 8'h00, "R1",
          "reset pins", {io_oe, io_out, rx_byte}, 16'h1000);
    mon_on = 1'b1;

    run_byte(0, 1'b0, 8'hA5, 8'h00, 1, 1'b0);  // R5 single write
    run_byte(0, 1'b1, 8'hFF, 8'h3C, 2, 1'b0);  // R7 R9 single read
    run_byte(1, 1'b0, 8'hB4, 8'h00, 0, 1'b0);  // R5 dual write, div 0 -> 1
    run_byte(1, 1'b1, 8'h00, 8'hC9, 3, 1'b0);  // R7 dual read
    run_byte(2, 1'b0, 8'h7E, 8'h00, 2, 1'b0);  // R5 quad write
    run_byte(2, 1'b1, 8'h00, 8'h5A, 1, 1'b0);  // R7 quad read
    run_byte(0, 1'b0, 8'h01, 8'h00, 4, 1'b0);  // R11 write keeps rx
    run_byte(1, 1'b1, 8'h00, 8'h96, 2, 1'b1);  // R10 poke during dual read
    run_byte(0, 1'b0, 8'h80, 8'h00, 5, 1'b1);  // R10 R3 poke during single write
    run_byte(2, 1'b1, 8'h00, 8'hE1, 0, 1'b0);  // R7 quad read, div 0

    // R2: lane code 3 is rejected
    @(negedge clk);
    lane_sel = 2'd3; start = 1'b1; dir_rd = 1'b0; tx_byte = 8'hFF;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    check(!busy && !sck, "R2", "code 3 not accepted", {busy, sck}, 0);
    check(rx_byte == rx_model, "R2", "rx unchanged after reject", rx_byte,
          rx_model);
    check(sb.size() == 0, "R10", "scoreboard drained", sb.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule